// File: doc/BRIEF.md
# Gated Programmable Sample Clock Divider

This block derives a slower sample-rate or left/right framing clock from a fast input clock. A division field sets the output period. A second field sets how many input cycles of each period the output spends high. Writing zero to the division field stops the output and holds it low. Any nonzero value N makes the output repeat every N+1 input cycles, so the smallest ratio is 2 and the largest is 2^DIV_W.

A parameter selects a build without the high-time field. That build makes a nominally balanced waveform by itself. New settings never cut a period short: the block samples both fields only at the boundary between two output periods. When the block starts from the stopped state it begins a fresh period at once, with the output high. A separate status output reports whether the division field currently asks the block to run.

Top module: `smpclk_div`

## Requirements
- R1: When the active division value is zero, clk_out is low. A change of div_val from nonzero to zero lets the running period finish, and clk_out then stays low.
- R2: For div_val = N with N >= 1, clk_out repeats every N+1 input clock cycles. N = 1 gives a period of 2.
- R3: The all-ones div_val gives a period of 2^DIV_W input cycles.
- R4: With HAS_HIGH = 1, each period begins with clk_out high for H+1 input cycles, where H = high_val, and clk_out is low for the rest of the period.
- R5: With HAS_HIGH = 1 and high_val >= div_val, clk_out stays high for the whole period. This is a clamp, not an error.
- R6: With HAS_HIGH = 0, high_val is ignored and clk_out is high for floor((N+1)/2) cycles of each N+1 cycle period.
- R7: running is 1 exactly when div_val is nonzero. It follows div_val in the same cycle.
- R8: A change to div_val or high_val in the middle of a period takes effect only at the next period boundary. The period in progress keeps its old length and high time.
- R9: When the block is stopped and div_val becomes nonzero, clk_out is high after the next clock edge, and that edge starts a new period.
- R10: A synchronous active-high rst drives clk_out low and clears the period position. At the first edge after rst falls with div_val nonzero, clk_out goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Division field; 0 stops the output, N divides by N+1 |
| high_val | input | DIV_W | High-time field; the output is high for value+1 cycles (unused when HAS_HIGH = 0) |
| clk_out | output | 1 | Divided clock, registered |
| running | output | 1 | 1 when div_val is nonzero |

## Verification
A wrong period position or a wrong latched setting shows at clk_out within one output period. It appears as a rising edge at the wrong point, a high pulse of the wrong width, or a period of the wrong length. The bench sweeps every division and high-time pair of a 4-bit configuration and measures the distance between rising edges and the width of the high pulse. A setting that is picked up too early shows as a shortened period right after a mid-period change, so the bench compares that exact sample sequence against the expected one. A start-up fault shows in the first sample after a restart or after reset.

// File: rtl/smpclk_div_pkg.sv
package smpclk_div_pkg;

  // Number of input cycles in one output period for a nonzero division value.
  function automatic int unsigned period_cycles(input int unsigned d);
    return d + 1;
  endfunction

  // Last period position (0-based) at which the output is still high.
  // prog=1: the high-time field is used, clamped to the division value.
  // prog=0: a balanced split is derived from the division value alone.
  function automatic int unsigned high_limit(input int unsigned d,
                                             input int unsigned h,
                                             input bit prog);
    if (d == 0) return 0;
    if (prog) return (h > d) ? d : h;
    return ((d + 1) / 2) - 1;
  endfunction

endpackage

// File: rtl/smpclk_cfg.sv
module smpclk_cfg #(
  parameter int DIV_W    = 8,
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [DIV_W-1:0] hi_in,
  output logic [DIV_W-1:0] act_div,
  output logic [DIV_W-1:0] act_hi,
  output logic [DIV_W-1:0] nxt_div,
  output logic [DIV_W-1:0] nxt_hi
);
  import smpclk_div_pkg::*;

  logic [DIV_W-1:0] eff_hi;

  generate
    if (HAS_HIGH) begin : g_prog
      assign eff_hi = DIV_W'(high_limit(32'(div_in), 32'(hi_in), 1'b1));
    end else begin : g_half
      logic unused_hi;
      assign unused_hi = ^hi_in;
      assign eff_hi = DIV_W'(high_limit(32'(div_in), 32'd0, 1'b0));
    end
  endgenerate

  assign nxt_div = load ? div_in : act_div;
  assign nxt_hi  = load ? eff_hi : act_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= '0;
      act_hi  <= '0;
    end else begin
      act_div <= nxt_div;
      act_hi  <= nxt_hi;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_div) && $stable(act_hi)));

  // R5
  hi_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_hi <= act_div);

endmodule

// File: rtl/smpclk_phase.sv
module smpclk_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] act_div,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] nxt_cnt,
  output logic             boundary
);

  assign boundary = (act_div == '0) || (cnt == act_div);
  assign nxt_cnt  = boundary ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt_cnt;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= act_div);

  // R1
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (act_div == '0) |-> (cnt == '0));

endmodule

// File: rtl/smpclk_wave.sv
module smpclk_wave #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] nxt_div,
  input  logic [DIV_W-1:0] nxt_hi,
  input  logic [DIV_W-1:0] nxt_cnt,
  input  logic [DIV_W-1:0] act_div,
  input  logic [DIV_W-1:0] act_hi,
  input  logic [DIV_W-1:0] cnt,
  output logic             clk_o
);

  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (nxt_div != '0) && (nxt_cnt <= nxt_hi);
  end

  assign clk_o = q;

  // R1
  gated_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_div == '0) |-> !clk_o);

  // R9
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_div != '0) && (cnt == '0)) |-> clk_o);

  // R8
  no_runt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> (cnt == '0));

  // R4
  low_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt > act_hi) |-> !clk_o);

endmodule

// File: rtl/smpclk_div.sv
module smpclk_div #(
  parameter int DIV_W    = 8,
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic [DIV_W-1:0] high_val,
  output logic             clk_out,
  output logic             running
);

  logic [DIV_W-1:0] act_div, act_hi, nxt_div, nxt_hi;
  logic [DIV_W-1:0] cnt, nxt_cnt;
  logic             boundary;

  smpclk_cfg #(.DIV_W(DIV_W), .HAS_HIGH(HAS_HIGH)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (boundary),
    .div_in  (div_val),
    .hi_in   (high_val),
    .act_div (act_div),
    .act_hi  (act_hi),
    .nxt_div (nxt_div),
    .nxt_hi  (nxt_hi)
  );

  smpclk_phase #(.DIV_W(DIV_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .act_div  (act_div),
    .cnt      (cnt),
    .nxt_cnt  (nxt_cnt),
    .boundary (boundary)
  );

  smpclk_wave #(.DIV_W(DIV_W)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .nxt_div (nxt_div),
    .nxt_hi  (nxt_hi),
    .nxt_cnt (nxt_cnt),
    .act_div (act_div),
    .act_hi  (act_hi),
    .cnt     (cnt),
    .clk_o   (clk_out)
  );

  assign running = (div_val != '0);

  // R10
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> !clk_out);

endmodule

// File: tb/smpclk_div_test.sv
module smpclk_div_test;
  localparam int W = 4;
  localparam int MAXD = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] div_val = '0;
  logic [W-1:0] high_val = '0;
  logic clk_out, running, clk_half, running_half;

  int n_chk = 0;
  int n_bad = 0;
  logic smp [0:63];
  logic smh [0:63];

  always #5 clk = ~clk;

  smpclk_div #(.DIV_W(W), .HAS_HIGH(1'b1)) uut (
    .clk(clk), .rst(rst), .div_val(div_val), .high_val(high_val),
    .clk_out(clk_out), .running(running));

  smpclk_div #(.DIV_W(W), .HAS_HIGH(1'b0)) uut_half (
    .clk(clk), .rst(rst), .div_val(div_val), .high_val(high_val),
    .clk_out(clk_half), .running(running_half));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (div=%0d high=%0d)",
               req, act, exp, div_val, high_val);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic grab(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp[k] = clk_out;
      smh[k] = clk_half;
    end
  endtask

  // Measures the distance between two rising edges and the high width in a captured window.
  task automatic measure(input bit half, output int per, output int hw, output bit full);
    int r1 = -1;
    int r2 = -1;
    full = 1'b1;
    hw = 0;
    for (int k = 0; k < 48; k++) if (!(half ? smh[k] : smp[k])) full = 1'b0;
    for (int k = 1; k < 48; k++) begin
      logic cur, prv;
      cur = half ? smh[k] : smp[k];
      prv = half ? smh[k-1] : smp[k-1];
      if (cur && !prv) begin
        if (r1 < 0) r1 = k;
        else if (r2 < 0) r2 = k;
      end
    end
    per = (r1 >= 0 && r2 >= 0) ? (r2 - r1) : -1;
    if (r1 >= 0)
      for (int k = r1; k < 48 && (half ? smh[k] : smp[k]); k++) hw++;
  endtask

  initial begin
    int per, hw, expp, exph;
    bit full;
    logic seq [0:12];

    // R10: reset state
    wait_neg(3);
    chk(clk_out == 1'b0, "R10 reset low", clk_out, 0);
    chk(running == 1'b0, "R7 idle status", running, 0);
    rst = 1'b0;
    wait_neg(4);
    chk(clk_out == 1'b0, "R1 zero div stays low", clk_out, 0);

    // Sweep all division/high pairs.
    for (int d = 1; d <= MAXD; d++) begin
      for (int h = 0; h <= MAXD; h++) begin
        div_val = W'(d);
        high_val = W'(h);
        #1;
        chk(running == 1'b1, "R7 running", running, 1);
        wait_neg(20);
        grab(48);
        expp = d + 1;
        exph = ((h > d) ? d : h) + 1;
        measure(1'b0, per, hw, full);
        if (h >= d) begin
          chk(full, "R5 full-high clamp", int'(full), 1);
        end else begin
          if (d == MAXD) chk(per == expp, "R3 max period", per, expp);
          else           chk(per == expp, "R2 period", per, expp);
          chk(hw == exph, "R4 high width", hw, exph);
        end
        measure(1'b1, per, hw, full);
        if (h == 0) begin
          chk(per == expp, "R6 half variant period", per, expp);
          chk(hw == (d + 1) / 2, "R6 half variant high", hw, (d + 1) / 2);
        end else begin
          chk(hw == (d + 1) / 2, "R6 high_val ignored", hw, (d + 1) / 2);
        end
      end
    end

    // R8: a mid-period change keeps the current period.
    div_val = 4'd7; high_val = 4'd3;
    wait_neg(20);
    begin
      logic prv;
      prv = 1'b1;
      for (int g = 0; g < 40; g++) begin
        @(negedge clk);
        if (clk_out && !prv) break;
        prv = clk_out;
      end
    end
    seq[0] = clk_out;
    @(negedge clk); seq[1] = clk_out;
    div_val = 4'd3; high_val = 4'd0;
    for (int k = 2; k <= 12; k++) begin @(negedge clk); seq[k] = clk_out; end
    for (int k = 0; k <= 12; k++) begin
      logic e;
      e = (k < 4) || (k == 8) || (k == 12);
      chk(seq[k] == e, "R8 boundary-only update", seq[k], e);
    end

    // R1: nonzero to zero finishes the period, then holds low.
    div_val = 4'd7; high_val = 4'd3;
    wait_neg(20);
    begin
      logic prv;
      prv = 1'b1;
      for (int g = 0; g < 40; g++) begin
        @(negedge clk);
        if (clk_out && !prv) break;
        prv = clk_out;
      end
    end
    seq[0] = clk_out;
    @(negedge clk); seq[1] = clk_out;
    div_val = 4'd0;
    #1;
    chk(running == 1'b0, "R7 status drops at once", running, 0);
    for (int k = 2; k <= 12; k++) begin @(negedge clk); seq[k] = clk_out; end
    for (int k = 0; k <= 12; k++) begin
      logic e;
      e = (k < 4);
      chk(seq[k] == e, "R1 finish then gate", seq[k], e);
    end
    grab(20);
    for (int k = 0; k < 20; k++) chk(smp[k] == 1'b0, "R1 held low", smp[k], 0);

    // R9: restart from idle begins high.
    div_val = 4'd2; high_val = 4'd0;
    grab(4);
    chk(smp[0] == 1'b1, "R9 restart high", smp[0], 1);
    chk(smp[1] == 1'b0, "R9 restart low", smp[1], 0);
    chk(smp[2] == 1'b0, "R9 restart low", smp[2], 0);
    chk(smp[3] == 1'b1, "R9 restart next period", smp[3], 1);

    // R10: reset during operation, then release.
    div_val = 4'd3; high_val = 4'd1;
    wait_neg(7);
    rst = 1'b1;
    grab(3);
    for (int k = 0; k < 3; k++) chk(smp[k] == 1'b0, "R10 reset low", smp[k], 0);
    rst = 1'b0;
    grab(5);
    chk(smp[0] == 1'b1, "R10 first edge high", smp[0], 1);
    chk(smp[1] == 1'b1, "R10 high width", smp[1], 1);
    chk(smp[2] == 1'b0, "R10 low phase", smp[2], 0);
    chk(smp[3] == 1'b0, "R10 low phase", smp[3], 0);
    chk(smp[4] == 1'b1, "R10 next period", smp[4], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule